// File: doc/BRIEF.md
# Pipelined Byte-Lane Synchronous SRAM

This block is a single-port synchronous memory whose words are made of byte lanes. Each lane holds eight data bits and one parity bit. The default build has four lanes, giving a 36-bit word, and a two-lane 18-bit build is also supported. Every control and data input is captured on the rising clock edge. A write is not committed to the array straight away: it waits in a one-entry write buffer and is committed on the following edge. Read data is loaded into an output register.

A write can cover any subset of lanes. Per-lane active-low enables select the lanes, but they take effect only while the active-low byte-write enable is low. An active-low all-lanes write overrides both. If a read follows a write to the same word, the read returns the lanes that were just written, taken from the write buffer, and the stored contents for the other lanes. The chip select is registered together with the address, so a deselected cycle drops out of the pipeline in step with the data. An asynchronous active-low output enable only gates the output bus and its valid flag.

Top module: `bytelane_sram`

## Requirements
- R1: A word holds LANES lanes of 9 bits, with LANES set to 2 or 4. Lane k occupies word bits [9k+8:9k]. Its parity bit is bit 9k+8 and its data bits are [9k+7:9k].
- R2: A read is a selected cycle that writes no lane. Its data is on `rdata` with `rvalid` high from the first rising edge after the read is sampled until the next rising edge.
- R3: When `bytewr_n` is high and `allwr_n` is high, `lane_wr_n` has no effect. The cycle is a read and no lane changes.
- R4: When `allwr_n` is low in a selected cycle, all lanes are written, whatever the values of `lane_wr_n` and `bytewr_n`.
- R5: When `bytewr_n` is low and `allwr_n` is high, exactly the lanes whose `lane_wr_n` bit is low are written. Each written lane updates its own 9 bits only. Any subset of one to LANES lanes is allowed.
- R6: A write cycle produces no output. `rvalid` is low during the cycle after the write is sampled.
- R7: A read sampled in the cycle right after a write to the same address returns the new contents in the written lanes and the stored contents in the other lanes.
- R8: A cycle sampled with `sel` low neither reads nor writes, whatever the write controls are. `rvalid` is low in the following cycle.
- R9: While `oe_n` is high, `rdata` is all zeros and `rvalid` is low, without waiting for a clock edge. Pulling `oe_n` low again shows the held read data right away if it is still valid.
- R10: While `rst_n` is low and after its release, `rvalid` is low and `rdata` is zero until a read completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low reset of the pipeline registers |
| sel | input | 1 | Chip select, active high, registered with the address |
| addr | input | AW | Word address |
| wdata | input | LANES*9 | Write data, lane k at bits [9k+8:9k] |
| lane_wr_n | input | LANES | Per-lane write enables, active low |
| bytewr_n | input | 1 | Qualifies the per-lane enables, active low |
| allwr_n | input | 1 | Writes all lanes, active low |
| oe_n | input | 1 | Asynchronous output enable, active low |
| rdata | output | LANES*9 | Read data, zero when not valid |
| rvalid | output | 1 | Read data valid |

## Verification
The assertions check the following on every cycle. They confirm how the write controls decode into a lane mask: the all-lanes override, the byte-write gating and the deselect. They check that a sampled write always lands in the write buffer with a non-empty mask, and that the output stays blank while the output enable is high. They also check that a read is followed by valid data one edge later and a non-read by no valid data. Only the bench's scenarios can show that the right lane contents come back. That covers partial-lane merges, forwarding from the write buffer to a read of the same word, back-to-back writes to one address, and the fact that ignored or deselected writes leave the array untouched.

// File: rtl/sram_pkg.sv
package sram_pkg;
   typedef enum logic [1:0] {
      OP_IDLE  = 2'd0,
      OP_READ  = 2'd1,
      OP_WRITE = 2'd2
   } sram_op_e;

   localparam int MAX_LANES = 4;
endpackage

// File: rtl/sram_cmd_reg.sv
module sram_cmd_reg
   import sram_pkg::*;
#(
   parameter int LANES = 4,
   parameter int LW    = 9,
   parameter int AW    = 8
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  sel,
   input  logic [AW-1:0]         addr,
   input  logic [LANES*LW-1:0]   wdata,
   input  logic [LANES-1:0]      lane_wr_n,
   input  logic                  bytewr_n,
   input  logic                  allwr_n,
   output sram_op_e              op_q,
   output logic [AW-1:0]         addr_q,
   output logic [LANES*LW-1:0]   wdata_q,
   output logic [LANES-1:0]      mask_q
);
   localparam int W = LANES * LW;

   logic [LANES-1:0] mask_c;
   sram_op_e         op_c;

   // per-lane decode of the write controls
   for (genvar g = 0; g < LANES; g++) begin : g_dec
      assign mask_c[g] = sel & (~allwr_n | (~bytewr_n & ~lane_wr_n[g]));
   end

   always_comb begin
      if (!sel)         op_c = OP_IDLE;
      else if (|mask_c) op_c = OP_WRITE;
      else              op_c = OP_READ;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         op_q    <= OP_IDLE;
         addr_q  <= '0;
         wdata_q <= '0;
         mask_q  <= '0;
      end else begin
         op_q    <= op_c;
         addr_q  <= addr;
         wdata_q <= wdata;
         mask_q  <= mask_c;
      end
   end

   AST_ALL_LANES_OVERRIDE: assert property (@(posedge clk) disable iff (!rst_n)
      (sel && !allwr_n) |=> (mask_q == {LANES{1'b1}} && op_q == OP_WRITE)); // R4
   AST_BYTE_ENABLE_GATES: assert property (@(posedge clk) disable iff (!rst_n)
      (sel && allwr_n && bytewr_n) |=> (mask_q == '0 && op_q == OP_READ)); // R3
   AST_DESELECT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!sel) |=> (op_q == OP_IDLE && mask_q == '0)); // R8

   logic unused_w;
   assign unused_w = ^W;
endmodule

// File: rtl/sram_lane_bank.sv
module sram_lane_bank #(
   parameter int AW = 8,
   parameter int LW = 9
) (
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [LW-1:0] wdata,
   input  logic [AW-1:0] raddr,
   output logic [LW-1:0] rdata
);
   localparam int DEPTH = 1 << AW;

   logic [LW-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
   end

   assign rdata = mem[raddr];
endmodule

// File: rtl/sram_write_buf.sv
module sram_write_buf
   import sram_pkg::*;
#(
   parameter int LANES = 4,
   parameter int LW    = 9,
   parameter int AW    = 8
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  sram_op_e              op_q,
   input  logic [AW-1:0]         addr_q,
   input  logic [LANES*LW-1:0]   wdata_q,
   input  logic [LANES-1:0]      mask_q,
   input  logic [LANES*LW-1:0]   arr_word,
   output logic                  commit_v,
   output logic [AW-1:0]         commit_addr,
   output logic [LANES*LW-1:0]   commit_data,
   output logic [LANES-1:0]      commit_mask,
   output logic [LANES*LW-1:0]   fwd_word
);
   logic                pend_v;
   logic [AW-1:0]       pend_addr;
   logic [LANES*LW-1:0] pend_data;
   logic [LANES-1:0]    pend_mask;
   logic                hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_v    <= 1'b0;
         pend_addr <= '0;
         pend_data <= '0;
         pend_mask <= '0;
      end else begin
         pend_v    <= (op_q == OP_WRITE);
         pend_addr <= addr_q;
         pend_data <= wdata_q;
         pend_mask <= (op_q == OP_WRITE) ? mask_q : '0;
      end
   end

   assign commit_v    = pend_v;
   assign commit_addr = pend_addr;
   assign commit_data = pend_data;
   assign commit_mask = pend_mask;

   assign hit = pend_v && (pend_addr == addr_q);

   // lane-wise merge of the pending write over the array word
   for (genvar g = 0; g < LANES; g++) begin : g_fwd
      assign fwd_word[g*LW +: LW] = (hit && pend_mask[g]) ? pend_data[g*LW +: LW]
                                                          : arr_word[g*LW +: LW];
   end

   AST_WRITE_BUFFERED: assert property (@(posedge clk) disable iff (!rst_n)
      (op_q == OP_WRITE) |=> (pend_v && pend_addr == $past(addr_q))); // R7
   AST_BUFFER_EMPTY_OTHERWISE: assert property (@(posedge clk) disable iff (!rst_n)
      (op_q != OP_WRITE) |=> !pend_v); // R8
   AST_PENDING_MASK_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      pend_v |-> (pend_mask != '0)); // R5
endmodule

// File: rtl/sram_read_out.sv
module sram_read_out
   import sram_pkg::*;
#(
   parameter int LANES = 4,
   parameter int LW    = 9
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  sram_op_e              op_q,
   input  logic [LANES*LW-1:0]   fwd_word,
   input  logic                  oe_n,
   output logic [LANES*LW-1:0]   rdata,
   output logic                  rvalid
);
   logic [LANES*LW-1:0] dout_q;
   logic                vld_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dout_q <= '0;
         vld_q  <= 1'b0;
      end else begin
         vld_q <= (op_q == OP_READ);
         if (op_q == OP_READ) dout_q <= fwd_word;
      end
   end

   assign rvalid = vld_q & ~oe_n;
   assign rdata  = rvalid ? dout_q : '0;

   AST_READ_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
      (op_q == OP_READ) |=> (oe_n || rvalid)); // R2
   AST_NO_DATA_AFTER_NONREAD: assert property (@(posedge clk) disable iff (!rst_n)
      (op_q != OP_READ) |=> (!rvalid && rdata == '0)); // R6
   AST_OE_BLANKS_BUS: assert property (@(posedge clk) disable iff (!rst_n)
      oe_n |-> (!rvalid && rdata == '0)); // R9
endmodule

// File: rtl/bytelane_sram.sv
module bytelane_sram
   import sram_pkg::*;
#(
   parameter int LANES     = 4,
   parameter int LANE_DATA = 8,
   parameter int LANE_PAR  = 1,
   parameter int AW        = 8
) (
   input  logic                                   clk,
   input  logic                                   rst_n,
   input  logic                                   sel,
   input  logic [AW-1:0]                          addr,
   input  logic [LANES*(LANE_DATA+LANE_PAR)-1:0]  wdata,
   input  logic [LANES-1:0]                       lane_wr_n,
   input  logic                                   bytewr_n,
   input  logic                                   allwr_n,
   input  logic                                   oe_n,
   output logic [LANES*(LANE_DATA+LANE_PAR)-1:0]  rdata,
   output logic                                   rvalid
);
   localparam int LW = LANE_DATA + LANE_PAR;
   localparam int W  = LANES * LW;

   // elaboration-time parameter checks
   if (LANES != 2 && LANES != 4) begin : g_bad_lanes
      $error("bytelane_sram: LANES must be 2 or 4");
   end
   if (LANES > MAX_LANES) begin : g_too_many
      $error("bytelane_sram: LANES above package limit");
   end
   if (LANE_DATA != 8 || LANE_PAR != 1) begin : g_bad_lane
      $error("bytelane_sram: a lane is 8 data bits plus 1 parity bit");
   end
   if (AW < 1 || AW > 12) begin : g_bad_aw
      $error("bytelane_sram: AW out of range 1..12");
   end

   sram_op_e         op_q;
   logic [AW-1:0]    addr_q;
   logic [W-1:0]     wdata_q;
   logic [LANES-1:0] mask_q;
   logic [W-1:0]     arr_word;
   logic             commit_v;
   logic [AW-1:0]    commit_addr;
   logic [W-1:0]     commit_data;
   logic [LANES-1:0] commit_mask;
   logic [W-1:0]     fwd_word;

   sram_cmd_reg #(.LANES(LANES), .LW(LW), .AW(AW)) u_cmd (
      .clk       (clk),
      .rst_n     (rst_n),
      .sel       (sel),
      .addr      (addr),
      .wdata     (wdata),
      .lane_wr_n (lane_wr_n),
      .bytewr_n  (bytewr_n),
      .allwr_n   (allwr_n),
      .op_q      (op_q),
      .addr_q    (addr_q),
      .wdata_q   (wdata_q),
      .mask_q    (mask_q)
   );

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      sram_lane_bank #(.AW(AW), .LW(LW)) u_bank (
         .clk   (clk),
         .we    (commit_v & commit_mask[g]),
         .waddr (commit_addr),
         .wdata (commit_data[g*LW +: LW]),
         .raddr (addr_q),
         .rdata (arr_word[g*LW +: LW])
      );
   end

   sram_write_buf #(.LANES(LANES), .LW(LW), .AW(AW)) u_wbuf (
      .clk         (clk),
      .rst_n       (rst_n),
      .op_q        (op_q),
      .addr_q      (addr_q),
      .wdata_q     (wdata_q),
      .mask_q      (mask_q),
      .arr_word    (arr_word),
      .commit_v    (commit_v),
      .commit_addr (commit_addr),
      .commit_data (commit_data),
      .commit_mask (commit_mask),
      .fwd_word    (fwd_word)
   );

   sram_read_out #(.LANES(LANES), .LW(LW)) u_rout (
      .clk      (clk),
      .rst_n    (rst_n),
      .op_q     (op_q),
      .fwd_word (fwd_word),
      .oe_n     (oe_n),
      .rdata    (rdata),
      .rvalid   (rvalid)
   );

   AST_RESET_QUIET: assert property (@(posedge clk)
      (!rst_n) |-> (!rvalid && rdata == '0)); // R10
endmodule

// File: tb/test_bytelane_sram.sv
module test_bytelane_sram;
   localparam int LANES = 4;
   localparam int LW    = 9;
   localparam int AW    = 8;
   localparam int W     = LANES * LW;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             sel = 1'b0;
   logic [AW-1:0]    addr = '0;
   logic [W-1:0]     wdata = '0;
   logic [LANES-1:0] lane_wr_n = '1;
   logic             bytewr_n = 1'b1;
   logic             allwr_n = 1'b1;
   logic             oe_n = 1'b0;
   logic [W-1:0]     rdata;
   logic             rvalid;

   always #5 clk = ~clk;

   bytelane_sram #(.LANES(LANES), .LANE_DATA(8), .LANE_PAR(1), .AW(AW)) i_bytelane_sram (
      .clk(clk), .rst_n(rst_n), .sel(sel), .addr(addr), .wdata(wdata),
      .lane_wr_n(lane_wr_n), .bytewr_n(bytewr_n), .allwr_n(allwr_n),
      .oe_n(oe_n), .rdata(rdata), .rvalid(rvalid)
   );

   int vectors = 0;
   int miscompares = 0;
   bit done = 1'b0;
   string tag = "R10";

   // behavioural reference: word store plus one-deep read expectation
   logic [W-1:0] model [int];
   logic         nxt_v = 1'b0;
   logic [W-1:0] nxt_d = '0;
   logic         exp_v = 1'b0;
   logic [W-1:0] exp_d = '0;

   task automatic check(input string t, input logic [W-1:0] got_d, input logic got_v,
                        input logic [W-1:0] want_d, input logic want_v);
      vectors++;
      if (got_d !== want_d || got_v !== want_v) begin
         miscompares++;
         $display("FAIL %s: actual rdata=%h rvalid=%b expected rdata=%h rvalid=%b",
                  t, got_d, got_v, want_d, want_v);
      end
   endtask

   function automatic logic [W-1:0] stored(input int a);
      if (model.exists(a)) return model[a];
      return '0;
   endfunction

   // one clock: drive at negedge, model at posedge, compare 2 ns later
   task automatic cyc(input logic s, input int a, input logic [W-1:0] d,
                      input logic [LANES-1:0] ln, input logic bw, input logic gw);
      logic [LANES-1:0] m;
      logic [W-1:0]     w;
      sel = s; addr = AW'(a); wdata = d; lane_wr_n = ln; bytewr_n = bw; allwr_n = gw;
      @(posedge clk);
      exp_v = nxt_v;
      exp_d = nxt_d;
      nxt_v = 1'b0;
      for (int k = 0; k < LANES; k++) m[k] = s & (~gw | (~bw & ~ln[k]));
      if (s && m != '0) begin
         w = stored(a);
         for (int k = 0; k < LANES; k++)
            if (m[k]) w[k*LW +: LW] = d[k*LW +: LW];
         model[a] = w;
      end else if (s) begin
         nxt_v = 1'b1;
         nxt_d = stored(a);
      end
      #2;
      check(tag, rdata, rvalid, (!oe_n && exp_v) ? exp_d : '0, !oe_n && exp_v);
      @(negedge clk);
   endtask

   task automatic rd(input int a);
      cyc(1'b1, a, '0, '1, 1'b1, 1'b1);
   endtask

   task automatic idle();
      cyc(1'b0, 0, '0, '1, 1'b1, 1'b1);
   endtask

   function automatic logic [W-1:0] rnd_word();
      logic [63:0] t;
      t = {$urandom, $urandom};
      return t[W-1:0];
   endfunction

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         miscompares++;
         $display("FAIL R2 watchdog: actual still running expected finished");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      check("R10 in reset", rdata, rvalid, '0, 1'b0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R10 after release", rdata, rvalid, '0, 1'b0);

      // fill addresses 0..15 with all-lanes writes; lane enables set against it
      tag = "R4 fill";
      for (int a = 0; a < 16; a++) cyc(1'b1, a, rnd_word(), '1, 1'b1, 1'b0);
      tag = "R2 readback";
      for (int a = 0; a < 16; a++) rd(a);
      idle();
      tag = "R4 override";
      cyc(1'b1, 3, 36'h1_2345_6789, 4'b1111, 1'b0, 1'b0);
      idle(); rd(3); idle();

      // byte-write enable high: lane enables ignored, cycle reads
      tag = "R3 ignored lanes";
      cyc(1'b1, 4, 36'hF_FFFF_FFFF, 4'b0000, 1'b1, 1'b1);
      idle(); rd(4); idle();

      // lane layout and subsets: lane k at bits [9k+8:9k], parity at 9k+8
      tag = "R1/R5 lane subsets";
      cyc(1'b1, 5, 36'h0_0000_0100, 4'b1110, 1'b0, 1'b1);
      idle(); rd(5); idle();
      cyc(1'b1, 6, 36'h8_0000_0000, 4'b0111, 1'b0, 1'b1);
      idle(); rd(6); idle();
      cyc(1'b1, 7, 36'hA_5A5A_5A5A, 4'b1010, 1'b0, 1'b1);
      idle(); rd(7); idle();
      cyc(1'b1, 8, 36'h5_A5A5_A5A5, 4'b0100, 1'b0, 1'b1);
      idle(); rd(8); idle();
      cyc(1'b1, 9, 36'h3_C3C3_C3C3, 4'b1111, 1'b0, 1'b1);
      idle(); rd(9); idle();

      // pass-through: read right after a partial write
      tag = "R7 pass-through";
      cyc(1'b1, 10, 36'h7_7777_7777, 4'b1010, 1'b0, 1'b1);
      rd(10); idle();
      cyc(1'b1, 11, 36'h1_1111_1111, 4'b1110, 1'b0, 1'b1);
      cyc(1'b1, 11, 36'h2_2222_2222, 4'b0111, 1'b0, 1'b1);
      rd(11); idle();
      cyc(1'b1, 12, 36'h9_9999_9999, 4'b0000, 1'b0, 1'b1);
      rd(13); rd(12); idle();

      tag = "R6 write then no output";
      rd(2);
      cyc(1'b1, 2, 36'h4_4444_4444, 4'b1111, 1'b1, 1'b0);
      cyc(1'b1, 2, 36'h6_6666_6666, 4'b1101, 1'b0, 1'b1);
      idle(); rd(2); idle();

      tag = "R8 deselect";
      cyc(1'b0, 14, 36'hE_EEEE_EEEE, 4'b0000, 1'b0, 1'b0);
      rd(14);
      cyc(1'b0, 14, '0, '1, 1'b1, 1'b1);
      idle();

      // asynchronous output enable on held data
      tag = "R9 oe";
      rd(15);
      idle();
      oe_n = 1'b1; #1;
      check("R9 oe high blanks", rdata, rvalid, '0, 1'b0);
      oe_n = 1'b0; #1;
      check("R9 oe low restores", rdata, rvalid, exp_d, exp_v);
      rd(1);
      oe_n = 1'b1;
      idle();
      oe_n = 1'b0;
      idle();

      tag = "R2/R5/R7 random";
      for (int n = 0; n < 1500; n++) begin
         int op;
         op = int'($urandom % 8);
         if (op < 3) rd(int'($urandom % 16));
         else if (op == 3) idle();
         else if (op == 4) cyc(1'b1, int'($urandom % 16), rnd_word(), '1, 1'b1, 1'b0);
         else cyc(1'b1, int'($urandom % 16), rnd_word(), LANES'($urandom),
                  1'(($urandom % 4) == 0), 1'b1);
      end
      idle(); idle();

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end
endmodule